// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves the outcome of a branch for a CPU with a 20-bit program address space. Given the address of the branch instruction, a branch kind code, the displacement and absolute address fields already pulled out of the instruction, the carry and zero flags, a tested bit supplied by the memory path, the AX register and a 4-bit code segment value, it decides whether the branch is taken. It then produces the next program counter and the number of clocks that branch kind costs.

The unit is one pipeline stage. A request presented with `req_valid` high produces a registered result one clock later, with `out_valid` high. Taken relative branches add a sign-extended displacement to the instruction's end address, which is the PC plus the length of the form (2, 3 or 4 bytes). Branches that are not taken continue at that end address. All address arithmetic wraps within the 20-bit space.

Top module: `br_unit`

## Requirements
- R1: `out_valid`, `next_pc`, `taken` and `cycles` are all zero during reset. A request with `req_valid`=1 is reflected on the outputs one clock later with `out_valid`=1. A cycle with `req_valid`=0 gives `out_valid`=0 and leaves `next_pc`, `taken` and `cycles` unchanged.
- R2: Kind 0 (register-indirect jump) is always taken, with `next_pc` = {`cs`, `ax`}.
- R3: Kind 1 (short relative jump) is taken to `pc`+2+sext(`disp[7:0]`). Kind 2 (long relative jump) is taken to `pc`+3+sext(`disp[15:0]`).
- R4: Kind 3 (16-bit absolute jump) is taken to {4'b0000, `abs_addr[15:0]`}. Kind 4 (20-bit absolute jump) is taken to `abs_addr`.
- R5: Kind 5 is taken when `flag_cy`=1, kind 6 when `flag_cy`=0, kind 7 when `flag_z`=1 and kind 8 when `flag_z`=0. The taken target is `pc`+2+sext(`disp[7:0]`).
- R6: Kind 9 (higher) is taken when (`flag_z` OR `flag_cy`)=0. Kind 10 (not higher) is taken when (`flag_z` OR `flag_cy`)=1. The taken target is `pc`+3+sext(`disp[7:0]`).
- R7: Kinds 11 to 16 are bit tests, taken when `test_bit`=1, with target `pc`+L+sext(`disp[7:0]`). L is 3 for kind 13 (accumulator bit) and kind 15 (HL-indirect bit). L is 4 for kind 11 (short direct), kind 12 (special register), kind 14 (status word) and kind 16 (segment plus HL).
- R8: A conditional kind (5 to 16) that is not taken gives `next_pc` = `pc`+L, where L is the length given in R5 to R7.
- R9: Kinds 0 to 4 report 3 cycles. Kinds 5 to 10 report 2 when not taken and 4 when taken.
- R10: Kinds 11 to 14 report 3 cycles when not taken and 5 when taken. Kind 15 reports 6 or 7, and kind 16 reports 7 or 8.
- R11: All PC arithmetic wraps modulo 2^20.
- R12: Kind codes 17 to 31 give `taken`=0, `cycles`=0 and `next_pc`=`pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| kind | input | 5 | Branch kind code |
| pc | input | 20 | Address of the branch instruction |
| disp | input | 16 | Displacement; the low byte is used by the short forms |
| abs_addr | input | 20 | Absolute target field |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| test_bit | input | 1 | Value of the tested bit |
| ax | input | 16 | AX register |
| cs | input | 4 | Code segment value |
| out_valid | output | 1 | Result valid |
| next_pc | output | 20 | Resolved next program counter |
| taken | output | 1 | Branch taken |
| cycles | output | 4 | Clock count of the branch |

## Verification
Each flag branch is driven with all four carry and zero combinations, so a swapped polarity or the wrong flag shows up as a taken mismatch. The bit tests are driven with both values of the tested bit, and each form is checked against its own length, which separates a length error of one byte from a condition error. Displacements at their sign extremes, and PCs near the top and bottom of the space, show sign-extension and wrap faults. A long random run with idle gaps and unused kind codes checks that results are held between requests and that unused codes are rejected.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int AW  = 20;
    localparam int SEGW = 4;
    localparam int CW  = 4;

    typedef enum logic [4:0] {
        K_IND    = 5'd0,
        K_REL8   = 5'd1,
        K_REL16  = 5'd2,
        K_ABS16  = 5'd3,
        K_ABS20  = 5'd4,
        K_CY     = 5'd5,
        K_NCY    = 5'd6,
        K_ZF     = 5'd7,
        K_NZF    = 5'd8,
        K_HI     = 5'd9,
        K_NHI    = 5'd10,
        K_BT_DIR = 5'd11,
        K_BT_REG = 5'd12,
        K_BT_ACC = 5'd13,
        K_BT_PSW = 5'd14,
        K_BT_HL  = 5'd15,
        K_BT_SHL = 5'd16
    } br_kind_e;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] pc;
        logic          taken;
        logic [CW-1:0] cycles;
    } br_res_t;
endpackage

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
(
    input  br_kind_e kind_i,
    input  logic     cy_i,
    input  logic     z_i,
    input  logic     bit_i,
    output logic     known_o,
    output logic     taken_o
);
    logic zc;

    always_comb begin
        zc      = z_i | cy_i;
        known_o = 1'b1;
        taken_o = 1'b0;
        case (kind_i)
            K_IND, K_REL8, K_REL16, K_ABS16, K_ABS20: taken_o = 1'b1;
            K_CY:   taken_o = cy_i;
            K_NCY:  taken_o = ~cy_i;
            K_ZF:   taken_o = z_i;
            K_NZF:  taken_o = ~z_i;
            K_HI:   taken_o = ~zc;
            K_NHI:  taken_o = zc;
            K_BT_DIR, K_BT_REG, K_BT_ACC,
            K_BT_PSW, K_BT_HL, K_BT_SHL: taken_o = bit_i;
            default: begin
                known_o = 1'b0;
                taken_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int SEG_W  = SEGW
) (
    input  br_kind_e          kind_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [15:0]       disp_i,
    input  logic [ADDR_W-1:0] abs_i,
    input  logic [15:0]       ax_i,
    input  logic [SEG_W-1:0]  cs_i,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] fall_o
);
    localparam int HI_W = ADDR_W - 16;

    logic [2:0]        len;
    logic [ADDR_W-1:0] ext8;
    logic [ADDR_W-1:0] ext16;
    logic [ADDR_W-1:0] disp_sel;

    always_comb begin
        ext8  = {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]};
        ext16 = {{(ADDR_W-16){disp_i[15]}}, disp_i};
        case (kind_i)
            K_REL8, K_CY, K_NCY, K_ZF, K_NZF:  len = 3'd2;
            K_REL16, K_HI, K_NHI,
            K_BT_ACC, K_BT_HL:                 len = 3'd3;
            K_BT_DIR, K_BT_REG,
            K_BT_PSW, K_BT_SHL:                len = 3'd4;
            default:                           len = 3'd0;
        endcase
        disp_sel = (kind_i == K_REL16) ? ext16 : ext8;
        fall_o   = pc_i + {{(ADDR_W-3){1'b0}}, len};
        case (kind_i)
            K_IND:   target_o = {cs_i, ax_i};
            K_ABS16: target_o = {{HI_W{1'b0}}, abs_i[15:0]};
            K_ABS20: target_o = abs_i;
            default: target_o = fall_o + disp_sel;
        endcase
    end
endmodule

// File: rtl/br_timing.sv
module br_timing
    import br_pkg::*;
#(
    parameter int CNT_W = CW
) (
    input  br_kind_e         kind_i,
    input  logic             taken_i,
    output logic [CNT_W-1:0] cycles_o
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] extra;

    always_comb begin
        extra = {CNT_W{1'b0}};
        case (kind_i)
            K_IND, K_REL8, K_REL16, K_ABS16, K_ABS20: base = CNT_W'(3);
            K_CY, K_NCY, K_ZF, K_NZF, K_HI, K_NHI: begin
                base  = CNT_W'(2);
                extra = CNT_W'(2);
            end
            K_BT_DIR, K_BT_REG, K_BT_ACC, K_BT_PSW: begin
                base  = CNT_W'(3);
                extra = CNT_W'(2);
            end
            K_BT_HL: begin
                base  = CNT_W'(6);
                extra = CNT_W'(1);
            end
            K_BT_SHL: begin
                base  = CNT_W'(7);
                extra = CNT_W'(1);
            end
            default: base = {CNT_W{1'b0}};
        endcase
        cycles_o = taken_i ? (base + extra) : base;
    end
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [4:0]      kind,
    input  logic [AW-1:0]   pc,
    input  logic [15:0]     disp,
    input  logic [AW-1:0]   abs_addr,
    input  logic            flag_cy,
    input  logic            flag_z,
    input  logic            test_bit,
    input  logic [15:0]     ax,
    input  logic [SEGW-1:0] cs,
    output logic            out_valid,
    output logic [AW-1:0]   next_pc,
    output logic            taken,
    output logic [CW-1:0]   cycles
);
    br_kind_e      kind_e;
    logic          known;
    logic          cond_taken;
    logic [AW-1:0] target;
    logic [AW-1:0] fall;
    logic [CW-1:0] cyc;
    br_res_t       res_d, res_q;

    assign kind_e = br_kind_e'(kind);

    br_cond u_cond (
        .kind_i (kind_e),
        .cy_i   (flag_cy),
        .z_i    (flag_z),
        .bit_i  (test_bit),
        .known_o(known),
        .taken_o(cond_taken)
    );

    br_target #(.ADDR_W(AW), .SEG_W(SEGW)) u_target (
        .kind_i  (kind_e),
        .pc_i    (pc),
        .disp_i  (disp),
        .abs_i   (abs_addr),
        .ax_i    (ax),
        .cs_i    (cs),
        .target_o(target),
        .fall_o  (fall)
    );

    br_timing #(.CNT_W(CW)) u_timing (
        .kind_i  (kind_e),
        .taken_i (cond_taken),
        .cycles_o(cyc)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (req_valid) begin
            res_d.valid  = 1'b1;
            res_d.taken  = cond_taken;
            res_d.cycles = cyc;
            if (!known)          res_d.pc = pc;
            else if (cond_taken) res_d.pc = target;
            else                 res_d.pc = fall;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign next_pc   = res_q.pc;
    assign taken     = res_q.taken;
    assign cycles    = res_q.cycles;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid) else $error("valid lost"); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(next_pc) && $stable(cycles))) else $error("idle changed"); // R1
    AST_IND_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == 5'd0) |=> (taken && next_pc == {$past(cs), $past(ax)})) else $error("indirect"); // R2
    AST_UNCOND_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind <= 5'd4) |=> (taken && cycles == CW'(3))) else $error("uncond"); // R9
    AST_FLAG_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind >= 5'd5 && kind <= 5'd10) |=> (cycles == (taken ? CW'(4) : CW'(2)))) else $error("flag cycles"); // R9
    AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind >= 5'd5 && kind <= 5'd16) |=>
        (taken || ((next_pc - $past(pc)) >= AW'(2) && (next_pc - $past(pc)) <= AW'(4)))) else $error("fallthrough"); // R8
    AST_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind >= 5'd11 && kind <= 5'd16) |=> (taken == $past(test_bit))) else $error("bit test"); // R7
    AST_UNKNOWN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind >= 5'd17) |=> (!taken && cycles == '0 && next_pc == $past(pc))) else $error("unknown"); // R12
endmodule

// File: tb/br_unit_tb.sv
module br_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = 20'hFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  kind = '0;
    logic [19:0] pc = '0;
    logic [15:0] disp = '0;
    logic [19:0] abs_addr = '0;
    logic        flag_cy = 1'b0;
    logic        flag_z = 1'b0;
    logic        test_bit = 1'b0;
    logic [15:0] ax = '0;
    logic [3:0]  cs = '0;
    logic        out_valid;
    logic [19:0] next_pc;
    logic        taken;
    logic [3:0]  cycles;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state expected after the next clock
    int    e_valid = 0, e_pc = 0, e_taken = 0, e_cyc = 0;
    string e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    br_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .pc(pc),
        .disp(disp), .abs_addr(abs_addr), .flag_cy(flag_cy), .flag_z(flag_z),
        .test_bit(test_bit), .ax(ax), .cs(cs), .out_valid(out_valid),
        .next_pc(next_pc), .taken(taken), .cycles(cycles)
    );

    function automatic string tag_of(int k);
        if (k == 0) return "R2";
        if (k <= 2) return "R3";
        if (k <= 4) return "R4";
        if (k <= 8) return "R5";
        if (k <= 10) return "R6";
        if (k <= 16) return "R7";
        return "R12";
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        string ctag;
        check(e_valid ? e_tag : "R1", "out_valid", int'(out_valid), e_valid);
        ctag = e_tag;
        if (e_valid && e_tag != "R11" && e_tag != "R12" && !e_taken && e_cyc != 3) ctag = "R8";
        check(e_valid ? ctag : "R1", "next_pc", int'(next_pc), e_pc);
        check(e_valid ? e_tag : "R1", "taken", int'(taken), e_taken);
        check(e_valid ? (kind_was_bit ? "R10" : "R9") : "R1", "cycles", int'(cycles), e_cyc);
    endtask

    bit kind_was_bit = 1'b0;

    // one cycle: compare last result, then present a new request
    task automatic step(bit v, int k, int p, int d, int a, bit c, bit z, bit b,
                        int x, int s, string force_tag);
        int len, sd8, sd16, tk, tgt, cy;
        @(negedge clk);
        compare_now();
        req_valid = v; kind = 5'(k); pc = 20'(p); disp = 16'(d); abs_addr = 20'(a);
        flag_cy = c; flag_z = z; test_bit = b; ax = 16'(x); cs = 4'(s);
        e_valid = v;
        if (!v) return;
        sd8  = (d & 8'h80) ? ((d & 8'hFF) - 256) : (d & 8'hFF);
        sd16 = (d & 16'h8000) ? ((d & 16'hFFFF) - 65536) : (d & 16'hFFFF);
        len = 0; tk = 0; cy = 0; tgt = 0;
        kind_was_bit = (k >= 11 && k <= 16);
        case (k)
            0: begin tk = 1; cy = 3; tgt = (s << 16) | (x & 16'hFFFF); end
            1: begin tk = 1; cy = 3; tgt = p + 2 + sd8; end
            2: begin tk = 1; cy = 3; tgt = p + 3 + sd16; end
            3: begin tk = 1; cy = 3; tgt = a & 16'hFFFF; end
            4: begin tk = 1; cy = 3; tgt = a; end
            5, 6, 7, 8: begin
                len = 2;
                tk = (k == 5) ? c : (k == 6) ? !c : (k == 7) ? z : !z;
                cy = tk ? 4 : 2;
            end
            9, 10: begin
                len = 3;
                tk = (k == 9) ? !(z || c) : (z || c);
                cy = tk ? 4 : 2;
            end
            11, 12, 14: begin len = 4; tk = b; cy = b ? 5 : 3; end
            13:         begin len = 3; tk = b; cy = b ? 5 : 3; end
            15:         begin len = 3; tk = b; cy = b ? 7 : 6; end
            16:         begin len = 4; tk = b; cy = b ? 8 : 7; end
            default:    begin tk = 0; cy = 0; tgt = p; end
        endcase
        if (k >= 5 && k <= 16) tgt = tk ? (p + len + sd8) : (p + len);
        e_pc = tgt & MASK;
        e_taken = tk;
        e_cyc = cy;
        e_tag = (force_tag != "") ? force_tag : tag_of(k);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset next_pc", int'(next_pc), 0);
        check("R1", "reset taken", int'(taken), 0);
        check("R1", "reset cycles", int'(cycles), 0);
        rst_n = 1'b1;
        e_valid = 0; e_pc = 0; e_taken = 0; e_cyc = 0;
        // R2 indirect
        step(1, 0, 20'h12345, 0, 0, 0, 0, 0, 16'hBEEF, 4'hA, "");
        // R3 relative, both sign extremes
        step(1, 1, 20'h01000, 16'h007F, 0, 0, 0, 0, 0, 0, "");
        step(1, 1, 20'h01000, 16'h0080, 0, 0, 0, 0, 0, 0, "");
        step(1, 2, 20'h40000, 16'h8000, 0, 0, 0, 0, 0, 0, "");
        step(1, 2, 20'h40000, 16'h7FFF, 0, 0, 0, 0, 0, 0, "");
        // R4 absolute
        step(1, 3, 20'h55555, 0, 20'hF1234, 0, 0, 0, 0, 0, "");
        step(1, 4, 20'h55555, 0, 20'hF1234, 0, 0, 0, 0, 0, "");
        // R5 / R6 every flag combination
        for (int k = 5; k <= 10; k++)
            for (int f = 0; f < 4; f++)
                step(1, k, 20'h20000 + f, 16'h0010, 0, f[0], f[1], 0, 0, 0, "");
        // R7 / R10 each bit form, both bit values
        for (int k = 11; k <= 16; k++)
            for (int b = 0; b < 2; b++)
                step(1, k, 20'h30000, 16'h00F0, 0, 0, 0, b[0], 0, 0, "");
        // R1 idle hold
        step(0, 1, 20'h99999, 0, 0, 0, 0, 0, 0, 0, "");
        step(0, 7, 20'h11111, 0, 0, 0, 1, 0, 0, 0, "");
        // R11 wrap at both ends
        step(1, 1, 20'hFFFFF, 16'h0005, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 2, 20'h00001, 16'hFF00, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 16, 20'hFFFFE, 16'h0000, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 11, 20'hFFFFD, 16'h007F, 0, 0, 0, 1, 0, 0, "R11");
        // R12 unknown kinds
        step(1, 17, 20'h0ABCD, 16'h1234, 20'h54321, 1, 1, 1, 0, 0, "");
        step(1, 31, 20'h0DCBA, 16'h1234, 20'h54321, 1, 1, 1, 0, 0, "");
        // random run
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, int'($urandom % 20), int'($urandom & MASK),
                 int'($urandom & 16'hFFFF), int'($urandom & MASK), $urandom % 2,
                 $urandom % 2, $urandom % 2, int'($urandom & 16'hFFFF),
                 int'($urandom % 16), "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        @(negedge clk);
        compare_now();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL watchdog expired actual=running expected=done");
                end
            end
            wait (done);
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule